// File: doc/BRIEF.md
# Phased External Memory Read Sequencer

This block runs single read accesses on an asynchronous external memory bus, timed by an internal timing clock. A requester presents an address together with a one-cycle `req` pulse. The block then walks the bus through three phases whose lengths are programmable: a setup phase (lead), a strobe phase (active) and a release phase (trail). It drives the chip-select, read strobe, write strobe, direction line and address. It samples the data bus at the moment the read strobe is released. When the access is over, it returns the captured word with a one-cycle `done` pulse.

The bus clock runs either at the timing-clock rate or at half of it. `bclk_phase` reports its level for each timing cycle. Every access must begin its lead phase in a cycle where the bus clock is high. When a request lands out of phase, one quiet alignment cycle is inserted first. A ready input can be enabled to hold the strobe phase open beyond its programmed length. The address bus is never released. It keeps the last address driven until the next lead phase loads a new one.

Top module: `ext_read_seq`

## Requirements
- R1: An accepted access passes through lead, then active, then trail. Each lead, active or trail phase lasts its programmed count in timing cycles, and a programmed count of 0 gives a one-cycle phase.
- R2: `bus_cs_n` is low in every lead, active and trail cycle and high otherwise. `bus_rd_n` is low only in active cycles.
- R3: In half-rate mode (`half_rate`=1), the first lead cycle always has `bclk_phase`=1. If the request is accepted in a cycle with `bclk_phase`=1, exactly one alignment cycle precedes lead; otherwise none does. In full-rate mode there is never an alignment cycle.
- R4: During an alignment cycle, `busy` is high and `bus_cs_n`, `bus_rd_n` and `bus_we_n` are all high.
- R5: `bus_addr` takes the requested address in the first lead cycle. It holds its previous value in every other cycle, including alignment and idle cycles.
- R6: With `use_ready`=0, `bus_ready` is ignored and the active phase lasts exactly its programmed count.
- R7: With `use_ready`=1, once the programmed active count has elapsed, the block stays in the active phase until it samples `bus_ready` high. The transition to trail happens at the end of the first cycle in which `bus_ready` is sampled high.
- R8: `rdata` holds the value of `bus_din` from the last active cycle, which is the cycle at whose end the read strobe rises.
- R9: `done` is high for exactly one cycle, the first cycle after the last trail cycle. In that cycle `busy` is low and `rdata` is valid.
- R10: A request made while `busy` is high is dropped. No further access follows, and the address bus is not changed.
- R11: `bus_we_n` and `bus_rnw` stay high at all times.
- R12: In full-rate mode `bclk_phase` stays at 1. In half-rate mode it toggles every timing cycle.
- R13: During reset, `busy`=0, `done`=0, `bus_cs_n`=`bus_rd_n`=1, `bclk_phase`=1 and `bus_addr`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_rate | input | 1 | 1: bus clock runs at half the timing clock |
| use_ready | input | 1 | 1: `bus_ready` can stretch the active phase |
| lead_cnt | input | CNT_W | Lead phase length in timing cycles (0 counts as 1) |
| active_cnt | input | CNT_W | Active phase length in timing cycles (0 counts as 1) |
| trail_cnt | input | CNT_W | Trail phase length in timing cycles (0 counts as 1) |
| req | input | 1 | Start a read; accepted only while idle |
| req_addr | input | ADDR_W | Address of the requested read |
| busy | output | 1 | An access (alignment, lead, active or trail) is in progress |
| done | output | 1 | One-cycle pulse, `rdata` valid |
| rdata | output | DATA_W | Captured read word |
| bus_ready | input | 1 | External ready |
| bus_din | input | DATA_W | External data bus |
| bclk_phase | output | 1 | Bus clock level in the current timing cycle |
| bus_cs_n | output | 1 | Chip-select, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_we_n | output | 1 | Write strobe, held inactive |
| bus_rnw | output | 1 | Direction, held at read (1) |
| bus_addr | output | ADDR_W | Address bus, held between accesses |

## Verification
A phase counter that loads the wrong value or misses a terminal count shows up within a single access. It appears as a chip-select or strobe window that is longer or shorter than the programmed count, visible by the first `done` pulse. A bus-clock phase tracker that is out of step yields a lead phase starting with `bclk_phase` low, or an alignment cycle that is missing or extra, and this is visible in the first cycle after the request. A slip in the capture point or the address register shows as a wrong `rdata` at `done`, or as a moving `bus_addr` during alignment or idle cycles, before the next access begins.

// File: rtl/ext_read_seq_pkg.sv
package ext_read_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ALIGN,
    ST_LEAD,
    ST_ACTIVE,
    ST_TRAIL
  } rd_state_e;

  // Effective phase length: a zero field still gives one cycle.
  function automatic int unsigned phase_len(input int unsigned field);
    return (field == 0) ? 1 : field;
  endfunction

  // An alignment cycle is needed when the next cycle would be a low bus-clock phase.
  function automatic logic need_align(input logic half, input logic ph_now);
    return half & ph_now;
  endfunction

endpackage

// File: rtl/ext_read_seq_bclk.sv
module ext_read_seq_bclk (
  input  logic clk,
  input  logic rst_n,
  input  logic half_rate,
  output logic bclk_phase
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bclk_phase <= 1'b1;
    else        bclk_phase <= half_rate ? ~bclk_phase : 1'b1;
  end

  assert_full_rate_high_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !half_rate |=> bclk_phase);

endmodule

// File: rtl/ext_read_seq_fsm.sv
module ext_read_seq_fsm
  import ext_read_seq_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             half_rate,
  input  logic             bclk_phase,
  input  logic             use_ready,
  input  logic [CNT_W-1:0] lead_cnt,
  input  logic [CNT_W-1:0] active_cnt,
  input  logic [CNT_W-1:0] trail_cnt,
  input  logic             bus_ready,
  output logic             accept,
  output logic             lead_go,
  output logic             cap_go,
  output logic             done,
  output logic             busy,
  output logic             cs_act,
  output logic             rd_act
);

  rd_state_e        state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lead_q, act_q, trail_q;
  logic             ur_q;
  logic             cnt_zero;
  logic             go_align;
  logic             trail_end;

  assign cnt_zero  = (cnt == '0);
  assign accept    = (state == ST_IDLE) && req;
  assign go_align  = accept && need_align(half_rate, bclk_phase);
  assign lead_go   = (accept && !go_align) || (state == ST_ALIGN);
  assign cap_go    = (state == ST_ACTIVE) && cnt_zero && (!ur_q || bus_ready);
  assign trail_end = (state == ST_TRAIL) && cnt_zero;

  assign busy   = (state != ST_IDLE);
  assign cs_act = (state == ST_LEAD) || (state == ST_ACTIVE) || (state == ST_TRAIL);
  assign rd_act = (state == ST_ACTIVE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      lead_q  <= '0;
      act_q   <= '0;
      trail_q <= '0;
      ur_q    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= trail_end;
      unique case (state)
        ST_IDLE: begin
          if (req) begin
            lead_q  <= lead_cnt;
            act_q   <= active_cnt;
            trail_q <= trail_cnt;
            ur_q    <= use_ready;
            cnt     <= CNT_W'(phase_len(32'(lead_cnt)) - 1);
            state   <= go_align ? ST_ALIGN : ST_LEAD;
          end
        end
        ST_ALIGN: begin
          cnt   <= CNT_W'(phase_len(32'(lead_q)) - 1);
          state <= ST_LEAD;
        end
        ST_LEAD: begin
          if (cnt_zero) begin
            cnt   <= CNT_W'(phase_len(32'(act_q)) - 1);
            state <= ST_ACTIVE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_ACTIVE: begin
          if (cap_go) begin
            cnt   <= CNT_W'(phase_len(32'(trail_q)) - 1);
            state <= ST_TRAIL;
          end else if (!cnt_zero) begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_TRAIL: begin
          if (cnt_zero) state <= ST_IDLE;
          else          cnt   <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_align_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ALIGN) |=> (state == ST_LEAD));

  assert_no_ready_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_ACTIVE) && cnt_zero && !ur_q) |=> (state == ST_TRAIL));

  assert_wait_for_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_ACTIVE) && cnt_zero && ur_q && !bus_ready) |=> (state == ST_ACTIVE));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

// File: rtl/ext_read_seq_dpath.sv
module ext_read_seq_dpath #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              lead_go,
  input  logic              cap_go,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] bus_din,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] rdata
);

  logic [ADDR_W-1:0] pend_q;
  logic [ADDR_W-1:0] addr_src;

  assign addr_src = accept ? req_addr : pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= '0;
      bus_addr <= '0;
      rdata    <= '0;
    end else begin
      if (accept)  pend_q   <= req_addr;
      if (lead_go) bus_addr <= addr_src;
      if (cap_go)  rdata    <= bus_din;
    end
  end

  assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !lead_go |=> $stable(bus_addr));

endmodule

// File: rtl/ext_read_seq.sv
module ext_read_seq #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              half_rate,
  input  logic              use_ready,
  input  logic [CNT_W-1:0]  lead_cnt,
  input  logic [CNT_W-1:0]  active_cnt,
  input  logic [CNT_W-1:0]  trail_cnt,
  input  logic              req,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  input  logic              bus_ready,
  input  logic [DATA_W-1:0] bus_din,
  output logic              bclk_phase,
  output logic              bus_cs_n,
  output logic              bus_rd_n,
  output logic              bus_we_n,
  output logic              bus_rnw,
  output logic [ADDR_W-1:0] bus_addr
);

  logic accept, lead_go, cap_go, cs_act, rd_act;

  ext_read_seq_bclk u_bclk (
    .clk        (clk),
    .rst_n      (rst_n),
    .half_rate  (half_rate),
    .bclk_phase (bclk_phase)
  );

  ext_read_seq_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .half_rate  (half_rate),
    .bclk_phase (bclk_phase),
    .use_ready  (use_ready),
    .lead_cnt   (lead_cnt),
    .active_cnt (active_cnt),
    .trail_cnt  (trail_cnt),
    .bus_ready  (bus_ready),
    .accept     (accept),
    .lead_go    (lead_go),
    .cap_go     (cap_go),
    .done       (done),
    .busy       (busy),
    .cs_act     (cs_act),
    .rd_act     (rd_act)
  );

  ext_read_seq_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .lead_go  (lead_go),
    .cap_go   (cap_go),
    .req_addr (req_addr),
    .bus_din  (bus_din),
    .bus_addr (bus_addr),
    .rdata    (rdata)
  );

  assign bus_cs_n = ~cs_act;
  assign bus_rd_n = ~rd_act;
  assign bus_we_n = 1'b1;
  assign bus_rnw  = 1'b1;

  assert_lead_on_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lead_go |=> bclk_phase);

  assert_align_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_cs_n) |-> bus_rd_n);

  assert_strobe_in_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_n |-> !bus_cs_n);

endmodule

// File: tb/ext_read_seq_bench.sv
module ext_read_seq_bench;
  localparam int AW = 19;
  localparam int DW = 16;
  localparam int CW = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n, half_rate, use_ready, req, bus_ready;
  logic [CW-1:0] lead_cnt, active_cnt, trail_cnt;
  logic [AW-1:0] req_addr, bus_addr;
  logic [DW-1:0] bus_din, rdata;
  logic          busy, done, bclk_phase, bus_cs_n, bus_rd_n, bus_we_n, bus_rnw;

  int n_cmp = 0;
  int n_bad = 0;

  ext_read_seq u_ext_read_seq (
    .clk(clk), .rst_n(rst_n), .half_rate(half_rate), .use_ready(use_ready),
    .lead_cnt(lead_cnt), .active_cnt(active_cnt), .trail_cnt(trail_cnt),
    .req(req), .req_addr(req_addr), .busy(busy), .done(done), .rdata(rdata),
    .bus_ready(bus_ready), .bus_din(bus_din), .bclk_phase(bclk_phase),
    .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_we_n(bus_we_n),
    .bus_rnw(bus_rnw), .bus_addr(bus_addr)
  );

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // Phase length per the requirement: fields below one count as one.
  function automatic int cycles_of(input int f);
    return (f < 1) ? 1 : f;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R9 actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  task automatic test_reset();
    check(busy == 1'b0 && done == 1'b0, "R13 busy/done in reset", {busy, done}, 0);
    check(bus_cs_n && bus_rd_n, "R13 strobes in reset", {bus_cs_n, bus_rd_n}, 3);
    check(bclk_phase == 1'b1, "R13 bus clock in reset", bclk_phase, 1);
    check(bus_addr == '0, "R13 address in reset", bus_addr, 0);
  endtask

  task automatic test_bclk(input bit hr);
    logic p0, p1, p2;
    half_rate = hr;
    repeat (2) @(negedge clk);
    p0 = bclk_phase;
    @(negedge clk) p1 = bclk_phase;
    @(negedge clk) p2 = bclk_phase;
    if (hr) check(p1 == ~p0 && p2 == p0, "R12 half-rate toggle", {p0, p1, p2}, {p0, ~p0, p0});
    else    check(p0 && p1 && p2, "R12 full-rate high", {p0, p1, p2}, 3'b111);
  endtask

  task automatic do_read(input logic [AW-1:0] a_addr, input int l, input int act, input int tr,
                         input bit ur, input int wt, input bit hr, input bit want_ph,
                         input bit inject, input string tag);
    int nal = 0, nle = 0, nac = 0, ntr = 0, guard = 0;
    int exp_al, exp_ac;
    bit al_addr_bad = 0, quiet_bad = 0, ctl_bad = 0, strobe_bad = 0;
    logic lead_ph = 1'b0;
    logic [AW-1:0] prev, lead_addr = '0;
    logic [DW-1:0] last_d = '0;
    half_rate = hr;
    @(negedge clk);
    @(negedge clk);
    while (busy) @(negedge clk);
    if (hr) while (bclk_phase != want_ph) @(negedge clk);
    prev   = bus_addr;
    exp_al = (hr && bclk_phase) ? 1 : 0;
    exp_ac = cycles_of(act) + (ur ? wt : 0);
    lead_cnt = CW'(l); active_cnt = CW'(act); trail_cnt = CW'(tr);
    use_ready = ur;
    req = 1'b1; req_addr = a_addr;
    while (guard < 300) begin
      @(negedge clk);
      guard++;
      req = 1'b0;
      bus_din = 16'h5A5A;
      bus_ready = 1'b0;
      if (done) break;
      if (!bus_we_n || !bus_rnw) ctl_bad = 1;
      if (!bus_rd_n && bus_cs_n) strobe_bad = 1;
      if (busy && bus_cs_n) begin
        nal++;
        if (!bus_rd_n || !bus_we_n) quiet_bad = 1;
        if (bus_addr !== prev) al_addr_bad = 1;
      end else if (!bus_cs_n && bus_rd_n && nac == 0) begin
        nle++;
        if (nle == 1) begin lead_ph = bclk_phase; lead_addr = bus_addr; end
      end else if (!bus_cs_n && !bus_rd_n) begin
        nac++;
        last_d = DW'(32'hA5A0 + nac * 13);
        bus_din = last_d;
        bus_ready = ur ? (nac >= cycles_of(act) + wt) : 1'b0;
        if (inject && nac == 1) begin req = 1'b1; req_addr = ~a_addr; end
      end else if (!bus_cs_n && bus_rd_n) begin
        ntr++;
      end
    end
    check(nal == exp_al, {"R3 alignment count ", tag}, nal, exp_al);
    check(lead_ph == 1'b1, {"R3 lead starts on high bus clock ", tag}, lead_ph, 1);
    check(nle == cycles_of(l), {"R1 lead length ", tag}, nle, cycles_of(l));
    check(nac == exp_ac, {ur ? "R7 stretched active " : "R6 active ignores ready ", tag}, nac, exp_ac);
    check(ntr == cycles_of(tr), {"R1 trail length ", tag}, ntr, cycles_of(tr));
    check(!strobe_bad, {"R2 strobe inside chip-select ", tag}, strobe_bad, 0);
    check(lead_addr == a_addr, {"R5 address at lead ", tag}, lead_addr, a_addr);
    if (exp_al == 1) begin
      check(!al_addr_bad, {"R5 address held in alignment ", tag}, al_addr_bad, 0);
      check(!quiet_bad, {"R4 quiet alignment ", tag}, quiet_bad, 0);
    end
    check(rdata == last_d, {"R8 captured data ", tag}, rdata, last_d);
    check(!ctl_bad, {"R11 write strobe and direction ", tag}, ctl_bad, 0);
    check(done && !busy, {"R9 done while idle ", tag}, {done, busy}, 2'b10);
    @(negedge clk);
    check(!done, {"R9 done single cycle ", tag}, done, 0);
    check(bus_addr == a_addr, {"R5 address held after access ", tag}, bus_addr, a_addr);
    if (inject) begin
      repeat (3) @(negedge clk);
      check(!busy && bus_cs_n, {"R10 request while busy dropped ", tag}, {busy, bus_cs_n}, 2'b01);
      check(bus_addr == a_addr, {"R10 address untouched ", tag}, bus_addr, a_addr);
    end
  endtask

  initial begin
    rst_n = 1'b0; half_rate = 1'b0; use_ready = 1'b0; req = 1'b0; bus_ready = 1'b0;
    lead_cnt = '0; active_cnt = '0; trail_cnt = '0; req_addr = '0; bus_din = '0;
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    test_bclk(1'b0);
    test_bclk(1'b1);
    do_read(19'h12345, 1, 1, 1, 1'b0, 0, 1'b0, 1'b0, 1'b0, "full minimal");
    do_read(19'h0ABCD, 3, 4, 2, 1'b0, 0, 1'b0, 1'b0, 1'b0, "full long");
    do_read(19'h7FFFF, 0, 0, 0, 1'b0, 0, 1'b0, 1'b0, 1'b0, "zero fields");
    do_read(19'h00F0F, 2, 3, 1, 1'b0, 0, 1'b1, 1'b1, 1'b0, "half with align");
    do_read(19'h31313, 2, 2, 2, 1'b0, 0, 1'b1, 1'b0, 1'b0, "half no align");
    do_read(19'h2468A, 1, 2, 1, 1'b1, 3, 1'b0, 1'b0, 1'b0, "ready wait 3");
    do_read(19'h13579, 1, 1, 3, 1'b1, 0, 1'b1, 1'b1, 1'b0, "ready at once half");
    do_read(19'h55555, 4, 2, 1, 1'b1, 2, 1'b1, 1'b0, 1'b0, "ready wait half");
    do_read(19'h0F0F0, 1, 5, 1, 1'b0, 7, 1'b0, 1'b0, 1'b0, "ready off");
    do_read(19'h1C0DE, 2, 2, 2, 1'b0, 0, 1'b0, 1'b0, 1'b1, "busy request");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule